// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the digital core of a half-bridge gate driver. It takes two interchangeable command inputs, an active-low shutdown, and two supply-good flags, and produces a high-side enable and a low-side enable. The two enables are complementary and never overlap. Each flag has already been debounced, and its hysteresis was applied outside the block. The two commands are ANDed. One command chooses which way current flows through the bridge. Holding the other one low brakes the load: the low-side switch stays on so the current decays slowly.

Every change from one side to the other passes through a both-off gap. The gap length comes from a cycle count on the `dead_cycles` input. The commands and supply flags pass through a two-flop synchronizer before use. Shutdown drops both enables at once, without waiting for a clock, and it is released through its own synchronizer. A bootstrap-charge enable mirrors the low-side enable, so the floating supply is recharged only while the low-side switch conducts.

The controller has four states. IDLE means both sides are off and no side is requested. GAP means both sides are off, a target side is latched, and the dead-time counter is running. HIGH means the high side is on. LOW means the low side is on. The transitions are:
- enter-gap: IDLE to GAP, when a side becomes requested.
- switch-over: HIGH or LOW to GAP, when the other side is requested.
- drop: HIGH or LOW to IDLE, when no side is requested.
- retarget: GAP to GAP, when the request changes to the other side; the count restarts from zero.
- abort: GAP to IDLE, when no side is requested.
- commit: GAP to HIGH or LOW, once the count has reached `dead_cycles`.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While `shut_n` is low, `hs_en` and `ls_en` are low in the same instant, with no clock edge needed. After `shut_n` returns high, the outputs stay off for 3 + `dead_cycles` sampled cycles before the requested side turns on.
- R2: The effective command is `dir_in AND run_in`. Swapping the values of the two inputs leaves all outputs unchanged.
- R3: With shutdown released and both supplies good, the outputs settle as follows. An effective command of 1 gives `hs_en`=1 and `ls_en`=0. A command of 0 gives `hs_en`=0 and `ls_en`=1. A command change reaches the outputs no earlier than the third clock edge after it.
- R4: While `run_in` is low, `ls_en` stays high and `hs_en` stays low, whatever `dir_in` does.
- R5: On every switch-over, in both directions, both outputs are low for exactly `dead_cycles` + 1 clock cycles.
- R6: `hs_en` and `ls_en` are never high in the same cycle. With `dead_cycles` = 0, a switch-over still leaves one cycle with both outputs off.
- R7: If the effective command reverts during a gap, the pending switch is abandoned and the count restarts from zero toward the side now requested. Reverting two cycles into a gap gives 2 + `dead_cycles` + 1 both-off cycles in total.
- R8: `boot_chg_en` equals `ls_en` in every cycle.
- R9: `lo_sup_ok` low forces both outputs off. `fl_sup_ok` low forces `hs_en` off but still lets `ls_en` turn on when the command is 0.
- R10: When a supply flag returns high, the controller starts from both-off. It applies 3 + `dead_cycles` off cycles, counted from release, before enabling the requested side.
- R11: After reset, both outputs and `boot_chg_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shut_n | input | 1 | Active-low shutdown; forces the outputs low asynchronously |
| dir_in | input | 1 | Command input A (direction), ANDed with B |
| run_in | input | 1 | Command input B; low means brake |
| lo_sup_ok | input | 1 | Low-side supply good (already debounced) |
| fl_sup_ok | input | 1 | Floating supply good (already debounced) |
| dead_cycles | input | DT_W | Dead time in clock cycles (gap = value + 1) |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| boot_chg_en | output | 1 | Bootstrap charge enable |

## Verification
The bench builds the block with `DT_W` = 6. This makes the largest dead time, 63 cycles, short enough to measure directly, so a 64-cycle gap at the top of the count is checked alongside zero and small values. Random stimulus uses short hold times and gaps of 0 to 5 cycles. This often brings command reversals inside a gap, supply drops during a gap, and shutdown pulses that arrive mid-transition.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } hb_state_e;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HIGH = 2'd1,
        SIDE_LOW  = 2'd2
    } hb_side_e;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbg_dt_timer.sv
module hbg_dt_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (restart)     cnt <= '0;
        else if (cnt < limit) cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= limit);

    // R7: a restart always brings the count back to zero
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/hbg_fsm.sv
module hbg_fsm
    import hbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      want_hs,
    input  logic      want_ls,
    input  logic      gap_done,
    output hb_state_e state,
    output logic      tmr_restart
);
    hb_state_e state_n;
    hb_side_e  tgt_q, tgt_n, want_side;

    always_comb begin
        if (want_hs)      want_side = SIDE_HIGH;
        else if (want_ls) want_side = SIDE_LOW;
        else              want_side = SIDE_NONE;
    end

    always_comb begin
        state_n     = state;
        tgt_n       = tgt_q;
        tmr_restart = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (want_side != SIDE_NONE) begin
                    state_n     = ST_GAP;
                    tgt_n       = want_side;
                    tmr_restart = 1'b1;
                end
            end
            ST_HIGH: begin
                if (want_side == SIDE_NONE) begin
                    state_n = ST_IDLE;
                end else if (want_side != SIDE_HIGH) begin
                    state_n     = ST_GAP;
                    tgt_n       = want_side;
                    tmr_restart = 1'b1;
                end
            end
            ST_LOW: begin
                if (want_side == SIDE_NONE) begin
                    state_n = ST_IDLE;
                end else if (want_side != SIDE_LOW) begin
                    state_n     = ST_GAP;
                    tgt_n       = want_side;
                    tmr_restart = 1'b1;
                end
            end
            ST_GAP: begin
                if (want_side == SIDE_NONE) begin
                    state_n = ST_IDLE;
                end else if (want_side != tgt_q) begin
                    tgt_n       = want_side;
                    tmr_restart = 1'b1;
                end else if (gap_done) begin
                    state_n = (tgt_q == SIDE_HIGH) ? ST_HIGH : ST_LOW;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tgt_q <= SIDE_NONE;
        end else begin
            state <= state_n;
            tgt_q <= tgt_n;
        end
    end

    // R5: a side is only entered from a gap whose count has completed
    assert_hs_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_HIGH) |-> ($past(state) == ST_GAP) && $past(gap_done));
    assert_ls_after_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_LOW) |-> ($past(state) == ST_GAP) && $past(gap_done));
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int DT_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shut_n,
    input  logic            dir_in,
    input  logic            run_in,
    input  logic            lo_sup_ok,
    input  logic            fl_sup_ok,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            hs_en,
    output logic            ls_en,
    output logic            boot_chg_en
);
    localparam int N_IN = 4;

    logic [N_IN-1:0] raw_in, syn_in;
    logic [0:0]      shut_q;
    logic            rel_n, shut_ok;
    logic            dir_s, run_s, lo_s, fl_s, eff_cmd;
    logic            want_hs, want_ls, gap_done, tmr_restart;
    hb_state_e       state;

    assign raw_in = {fl_sup_ok, lo_sup_ok, run_in, dir_in};

    hbg_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) i_in_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    assign rel_n = rst_n & shut_n;

    hbg_sync #(.W(1), .STAGES(SYNC_STAGES)) i_shut_sync (
        .clk(clk), .rst_n(rel_n), .d(1'b1), .q(shut_q)
    );

    assign dir_s   = syn_in[0];
    assign run_s   = syn_in[1];
    assign lo_s    = syn_in[2];
    assign fl_s    = syn_in[3];
    assign shut_ok = shut_q[0];
    assign eff_cmd = dir_s & run_s;
    assign want_hs = eff_cmd & lo_s & fl_s & shut_ok;
    assign want_ls = ~eff_cmd & lo_s & shut_ok;

    hbg_dt_timer #(.CW(DT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
        .limit(dead_cycles), .done(gap_done)
    );

    hbg_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .want_hs(want_hs), .want_ls(want_ls),
        .gap_done(gap_done), .state(state), .tmr_restart(tmr_restart)
    );

    always_comb begin
        hs_en       = (state == ST_HIGH) && shut_n;
        ls_en       = (state == ST_LOW) && shut_n;
        boot_chg_en = ls_en;
    end

    // R6: the two gate enables never overlap
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));
    // R1: a held shutdown leaves the controller idle
    assert_shut_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_ok |=> (state == ST_IDLE));
    // R9: low-side undervoltage turns both sides off at the next edge
    assert_lo_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_s |=> (state == ST_IDLE));
    // R9: floating-supply undervoltage keeps the high side off
    assert_fl_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_s |=> (state != ST_HIGH));
    // R4: brake keeps the high side off
    assert_brake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> (state != ST_HIGH));
endmodule

// File: tb/test_hb_gate_ctrl.sv
module test_hb_gate_ctrl;
    localparam int DT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shut_n = 1'b1, dir_in = 1'b0, run_in = 1'b1;
    logic lo_sup_ok = 1'b1, fl_sup_ok = 1'b1;
    logic [DT_W-1:0] dead_cycles = '0;
    logic hs_en, ls_en, boot_chg_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hb_gate_ctrl #(.DT_W(DT_W), .SYNC_STAGES(2)) i_hb_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .shut_n(shut_n), .dir_in(dir_in), .run_in(run_in),
        .lo_sup_ok(lo_sup_ok), .fl_sup_ok(fl_sup_ok), .dead_cycles(dead_cycles),
        .hs_en(hs_en), .ls_en(ls_en), .boot_chg_en(boot_chg_en)
    );

    // Reference model built from the requirements: 0 idle, 1 gap, 2 high, 3 low
    logic [3:0] m_p1, m_p2;
    logic [1:0] m_sh;
    int m_st, m_tgt, m_cnt;
    int w_side, n_st, n_tgt;
    bit n_rst;
    bit m_eff;

    always @(posedge clk or negedge rst_n or negedge shut_n) begin
        if (!rst_n || !shut_n) m_sh <= 2'b00;
        else                   m_sh <= {m_sh[0], 1'b1};
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p1 <= '0; m_p2 <= '0; m_st <= 0; m_tgt <= 0; m_cnt <= 0;
        end else begin
            m_eff = m_p2[0] & m_p2[1];
            if (m_eff && m_p2[2] && m_p2[3] && m_sh[1])  w_side = 1;
            else if (!m_eff && m_p2[2] && m_sh[1])       w_side = 2;
            else                                          w_side = 0;
            n_st = m_st; n_tgt = m_tgt; n_rst = 1'b0;
            case (m_st)
                0: if (w_side != 0) begin n_st = 1; n_tgt = w_side; n_rst = 1'b1; end
                2: if (w_side == 0) n_st = 0;
                   else if (w_side != 1) begin n_st = 1; n_tgt = w_side; n_rst = 1'b1; end
                3: if (w_side == 0) n_st = 0;
                   else if (w_side != 2) begin n_st = 1; n_tgt = w_side; n_rst = 1'b1; end
                default: if (w_side == 0) n_st = 0;
                   else if (w_side != m_tgt) begin n_tgt = w_side; n_rst = 1'b1; end
                   else if (m_cnt >= int'(dead_cycles)) n_st = (m_tgt == 1) ? 2 : 3;
            endcase
            m_p1  <= {fl_sup_ok, lo_sup_ok, run_in, dir_in};
            m_p2  <= m_p1;
            m_st  <= n_st;
            m_tgt <= n_tgt;
            if (n_rst) m_cnt <= 0;
            else if (m_cnt < int'(dead_cycles)) m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: {hs,ls,boot} actual=%b expected=%b at %0t", tag, act, exp_v, $time);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic step(input string tag);
        logic eh, el;
        @(negedge clk);
        eh = (m_st == 2) && shut_n;
        el = (m_st == 3) && shut_n;
        chk(tag, {hs_en, ls_en, boot_chg_en}, {eh, el, el});
    endtask

    task automatic steps(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic count_off(input string tag, output int n);
        int guard = 0;
        n = 0;
        step(tag);
        while ((hs_en || ls_en) && guard < 300) begin step(tag); guard++; end
        while (!hs_en && !ls_en && guard < 300) begin n++; step(tag); guard++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R11 reset", {hs_en, ls_en, boot_chg_en}, 3'b000);
        rst_n = 1'b1;
        step("R11 after reset");

        // R3 steady states
        dead_cycles = 2; dir_in = 1; run_in = 1;
        steps("R3", 10);
        chk("R3 high side", {hs_en, ls_en, boot_chg_en}, 3'b100);
        dir_in = 0; steps("R3", 10);
        chk("R3 low side", {hs_en, ls_en, boot_chg_en}, 3'b011);
        chk("R8 boot follows low", {boot_chg_en}, {ls_en});

        // R2 interchangeable inputs
        dir_in = 1; run_in = 0; steps("R2", 10);
        chk("R2 a=1 b=0", {hs_en, ls_en, boot_chg_en}, 3'b011);
        dir_in = 0; run_in = 1; steps("R2", 10);
        chk("R2 a=0 b=1", {hs_en, ls_en, boot_chg_en}, 3'b011);

        // R4 brake while direction toggles
        run_in = 0;
        for (int i = 0; i < 20; i++) begin
            dir_in = ~dir_in; step("R4");
            chk("R4 brake holds low side", {hs_en, ls_en}, 2'b01);
        end
        run_in = 1; dir_in = 0; steps("R4", 8);

        // R5 gap in both directions
        dead_cycles = 3;
        dir_in = 1; count_off("R5 low to high", n); chk_int("R5 low to high gap", n, 4);
        steps("R5", 4);
        dir_in = 0; count_off("R5 high to low", n); chk_int("R5 high to low gap", n, 4);
        steps("R5", 4);

        // R6 zero dead time
        dead_cycles = 0;
        dir_in = 1; count_off("R6", n); chk_int("R6 zero dead time gap", n, 1);
        steps("R6", 4);
        dir_in = 0; count_off("R6", n); chk_int("R6 zero dead time gap back", n, 1);
        steps("R6", 4);

        // largest count
        dead_cycles = 63;
        dir_in = 1; count_off("R5 max", n); chk_int("R5 max dead time gap", n, 64);
        steps("R5", 4);

        // R7 abandon: revert two cycles into the gap
        dead_cycles = 5;
        dir_in = 0; step("R7"); step("R7");
        dir_in = 1; count_off("R7", n); chk_int("R7 abandoned switch gap", n, 8);
        chk("R7 back on high", {hs_en, ls_en}, 2'b10);
        steps("R7", 4);

        // R9 supply faults
        fl_sup_ok = 0; steps("R9", 6);
        chk("R9 floating fault high off", {hs_en, ls_en}, 2'b00);
        dir_in = 0; steps("R9", 12);
        chk("R9 floating fault low allowed", {hs_en, ls_en}, 2'b01);
        lo_sup_ok = 0; steps("R9", 6);
        chk("R9 low supply fault", {hs_en, ls_en}, 2'b00);
        fl_sup_ok = 1; dir_in = 1; steps("R9", 4);

        // R10 release from undervoltage
        dead_cycles = 4;
        lo_sup_ok = 1; count_off("R10", n); chk_int("R10 release gap", n, 7);
        chk("R10 high after release", {hs_en, ls_en}, 2'b10);

        // R1 asynchronous shutdown
        #1 shut_n = 0; #1;
        chk("R1 immediate off", {hs_en, ls_en, boot_chg_en}, 3'b000);
        steps("R1", 5);
        shut_n = 1; count_off("R1", n); chk_int("R1 release gap", n, 7);

        // random phase
        for (int it = 0; it < 400; it++) begin
            if (it % 25 == 0) dead_cycles = DT_W'($urandom_range(0, 5));
            dir_in    = 1'($urandom_range(0, 1));
            run_in    = ($urandom_range(0, 9) < 8);
            lo_sup_ok = ($urandom_range(0, 19) < 18);
            fl_sup_ok = ($urandom_range(0, 19) < 18);
            if ($urandom_range(0, 29) == 0) begin
                #1 shut_n = 0;
                steps("R1 random", 2);
                shut_n = 1;
            end
            steps("R3 random", $urandom_range(1, 12));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule